// File: doc/BRIEF.md
# Flash Controller Guarded Register Bank

This block is the software-visible register file of a flash memory controller. It keeps the interface configuration (bus width, address length, block size, write protection) and the flash bus timing settings, and it shields both from stray writes behind a one-shot unlock key. A key write opens the guarded registers for a single write. After that write the guard closes again without any further action, so each guarded update needs its own key.

The bank also collects the controller's datapath events. Rising edges of the device-ready and controller-ready levels are latched as interrupt causes. So are completion pulses from the error-correction engine, which arrive together with their error and failure flags, and write-protect fault pulses. Reading the latched cause register returns its contents and clears it in the same access. A mask register selects which causes drive the level interrupt line. A separate live status register reports the ready levels and the result of the most recent decode, and a chip-enable mode register selects whether the controller drives the chip enable.

Register offsets are word addresses: 0 configuration, 1 timing, 2 interrupt mask, 3 latched causes, 4 live status, 5 lock, 6 chip-enable mode.

Top module: `flash_regbank`

## Requirements
- R1: After reset every register reads zero, the guard is closed (lock address 5 reads 0), all outputs are zero and `irq` is low.
- R2: A write to address 5 whose low 16 bits equal 0xA25E opens the guard, and address 5 then reads 1. A write to address 5 with any other low 16 bits closes it, and address 5 then reads 0. Upper data bits are ignored.
- R3: While the guard is open, a write to address 0 stores bits [3:0] (bit 3 write protect, bit 2 large block, bit 1 five-byte address, bit 0 16-bit bus) on `cfg_bits`. The write closes the guard, so a second write without a new key leaves the value unchanged.
- R4: A write to address 0 or 1 while the guard is closed changes no register and leaves the guard closed.
- R5: While the guard is open, a write to address 1 stores bits [25:0] and closes the guard. The fields are [25:24] `tm_ce_dly`, [23:19] `tm_busy`, [18:16] `tm_turn`, [15:12] `tm_rd_hi`, [11:8] `tm_rd_lo`, [7:4] `tm_wr_hi` and [3:0] `tm_wr_lo`.
- R6: The mask at address 2 (bits [5:0]) and the chip-enable mode at address 6 (bit 0, driving `ce_by_ctrl`) are written without a key and read back.
- R7: Address 3 latches the causes with this layout: bit 5 rising `dev_ready`, bit 4 rising `ctl_ready`, bit 3 `ecc_done` with `dec_fail`, bit 2 `ecc_done` with `dec_err`, bit 1 `ecc_done`, bit 0 `wp_fault`.
- R8: A read of address 3 returns the latched causes, and after that cycle they are zero.
- R9: A cause that arrives in the same cycle as a read of address 3 is not in that read's data but remains latched afterwards.
- R10: `irq` is high from the cycle after a latched cause bit and its mask bit are both set, and low when no latched bit is masked in.
- R11: Address 4 reads bit 6 last decode failure, bits [5:4] last error count, bit 3 last errors detected, bit 2 decode result valid, bit 1 `ctl_ready` and bit 0 `dev_ready`. Bits 6..2 load on `ecc_done` and clear on a falling `ctl_ready` edge.
- R12: Reads of any address above 6 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of address 3 clears it) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| dev_ready | input | 1 | Flash device ready level |
| ctl_ready | input | 1 | Controller ready level |
| ecc_done | input | 1 | Decode complete pulse |
| dec_err | input | 1 | Errors detected, qualified by ecc_done |
| dec_fail | input | 1 | Uncorrectable, qualified by ecc_done |
| err_cnt | input | 2 | Corrected error count minus one |
| wp_fault | input | 1 | Write-protect fault pulse |
| cfg_bits | output | 4 | Interface configuration |
| tm_ce_dly | output | 2 | Chip-enable to access delay |
| tm_busy | output | 5 | Busy delay |
| tm_turn | output | 3 | Bus turnaround |
| tm_rd_hi | output | 4 | Read strobe high time |
| tm_rd_lo | output | 4 | Read strobe low time |
| tm_wr_hi | output | 4 | Write strobe high time |
| tm_wr_lo | output | 4 | Write strobe low time |
| ce_by_ctrl | output | 1 | Chip enable driven by the controller |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the bank with its defaults: a 4-bit address, 32-bit data and the 16-bit key 0xA25E. The 4-bit address reaches unmapped words 7 through 15, and the 32-bit data path lets the bench set upper bits that must be ignored, both beside the key and above the 26 timing bits. A behavioural model tracks the guard, every register and the expected interrupt level on each clock. Directed sequences then cover a key followed by two writes, a wrong key, and a cause that lands in the same cycle as the clearing read.

// File: rtl/flash_regbank_pkg.sv
package flash_regbank_pkg;

   // word offsets
   localparam int unsigned A_CFG  = 0;
   localparam int unsigned A_TIM  = 1;
   localparam int unsigned A_MASK = 2;
   localparam int unsigned A_RAW  = 3;
   localparam int unsigned A_LIVE = 4;
   localparam int unsigned A_LOCK = 5;
   localparam int unsigned A_CE   = 6;

   // interrupt cause bit positions (mask and latched share them)
   localparam int unsigned IB_WPF   = 0;
   localparam int unsigned IB_ECC   = 1;
   localparam int unsigned IB_DERR  = 2;
   localparam int unsigned IB_DFAIL = 3;
   localparam int unsigned IB_CTL   = 4;
   localparam int unsigned IB_DEV   = 5;
   localparam int unsigned IRQ_N    = 6;

   localparam int unsigned CFG_W  = 4;
   localparam int unsigned TIM_W  = 26;
   localparam int unsigned CNT_W  = 2;
   localparam int unsigned RES_W  = CNT_W + 3;
   localparam int unsigned LIVE_W = RES_W + 2;

   typedef struct packed {
      logic [1:0] ce_dly;
      logic [4:0] busy;
      logic [2:0] turn;
      logic [3:0] rd_hi;
      logic [3:0] rd_lo;
      logic [3:0] wr_hi;
      logic [3:0] wr_lo;
   } timing_t;

endpackage

// File: rtl/frb_keylock.sv
module frb_keylock #(
   parameter int unsigned KEY_W = 16,
   parameter logic [KEY_W-1:0] KEY = 16'hA25E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_wr,
   input  logic [KEY_W-1:0] key_in,
   input  logic             prot_wr,
   output logic             unlocked,
   output logic             prot_we
);

   logic open_q;

   assign prot_we  = prot_wr & open_q;
   assign unlocked = open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       open_q <= 1'b0;
      else if (lock_wr) open_q <= (key_in == KEY);
      else if (prot_we) open_q <= 1'b0;
   end

   assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && key_in == KEY) |=> unlocked);

   assert_relock_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_wr && unlocked && !lock_wr) |=> !unlocked);

   assert_locked_stays_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && !lock_wr) |=> !unlocked);

endmodule

// File: rtl/frb_irq_latch.sv
module frb_irq_latch #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] latched
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      latched[i] <= 1'b0;
         else if (set[i]) latched[i] <= 1'b1;
         else if (clr)    latched[i] <= 1'b0;
      end
   end

   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (latched == $past(set)));

   assert_event_survives_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((latched & $past(set)) == $past(set)));

endmodule

// File: rtl/frb_live_status.sv
module frb_live_status #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ecc_done,
   input  logic             dec_fail,
   input  logic             dec_err,
   input  logic [CNT_W-1:0] err_cnt,
   input  logic             ctl_fall,
   output logic [CNT_W+2:0] result
);

   logic             fail_q, det_q, valid_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_q <= 1'b0; det_q <= 1'b0; valid_q <= 1'b0; cnt_q <= '0;
      end else if (ecc_done) begin
         fail_q <= dec_fail; det_q <= dec_err; valid_q <= 1'b1; cnt_q <= err_cnt;
      end else if (ctl_fall) begin
         fail_q <= 1'b0; det_q <= 1'b0; valid_q <= 1'b0; cnt_q <= '0;
      end
   end

   assign result = {fail_q, cnt_q, det_q, valid_q};

   assert_live_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_done |=> (result[0] && result[CNT_W+2] == $past(dec_fail)
                    && result[1] == $past(dec_err)));

endmodule

// File: rtl/flash_regbank.sv
module flash_regbank
   import flash_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned KEY_W  = 16,
   parameter logic [KEY_W-1:0] KEY = 16'hA25E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              dev_ready,
   input  logic              ctl_ready,
   input  logic              ecc_done,
   input  logic              dec_err,
   input  logic              dec_fail,
   input  logic [1:0]        err_cnt,
   input  logic              wp_fault,
   output logic [3:0]        cfg_bits,
   output logic [1:0]        tm_ce_dly,
   output logic [4:0]        tm_busy,
   output logic [2:0]        tm_turn,
   output logic [3:0]        tm_rd_hi,
   output logic [3:0]        tm_rd_lo,
   output logic [3:0]        tm_wr_hi,
   output logic [3:0]        tm_wr_lo,
   output logic              ce_by_ctrl,
   output logic              irq
);

   localparam int unsigned MIN_ADDR_W = $clog2(A_CE + 1);

   if (DATA_W < TIM_W) begin : g_bad_data_w
      $error("DATA_W too narrow for the timing register");
   end
   if (KEY_W > DATA_W) begin : g_bad_key_w
      $error("KEY_W wider than DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register map");
   end

   // decode
   logic sel_cfg, sel_tim, sel_mask, sel_raw, sel_live, sel_lock, sel_ce;
   assign sel_cfg  = (bus_addr == ADDR_W'(A_CFG));
   assign sel_tim  = (bus_addr == ADDR_W'(A_TIM));
   assign sel_mask = (bus_addr == ADDR_W'(A_MASK));
   assign sel_raw  = (bus_addr == ADDR_W'(A_RAW));
   assign sel_live = (bus_addr == ADDR_W'(A_LIVE));
   assign sel_lock = (bus_addr == ADDR_W'(A_LOCK));
   assign sel_ce   = (bus_addr == ADDR_W'(A_CE));

   // guard
   logic unlocked, prot_we;
   frb_keylock #(.KEY_W(KEY_W), .KEY(KEY)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_wr  (bus_wr & sel_lock),
      .key_in   (bus_wdata[KEY_W-1:0]),
      .prot_wr  (bus_wr & (sel_cfg | sel_tim)),
      .unlocked (unlocked),
      .prot_we  (prot_we)
   );

   // plain and guarded registers
   logic [CFG_W-1:0] cfg_q;
   timing_t          tim_q;
   logic [IRQ_N-1:0] mask_q;
   logic             ce_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         tim_q  <= '0;
         mask_q <= '0;
         ce_q   <= 1'b0;
      end else begin
         if (prot_we && sel_cfg)  cfg_q  <= bus_wdata[CFG_W-1:0];
         if (prot_we && sel_tim)  tim_q  <= timing_t'(bus_wdata[TIM_W-1:0]);
         if (bus_wr && sel_mask)  mask_q <= bus_wdata[IRQ_N-1:0];
         if (bus_wr && sel_ce)    ce_q   <= bus_wdata[0];
      end
   end

   // ready edge detection
   logic dev_q, ctl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_q <= 1'b0;
         ctl_q <= 1'b0;
      end else begin
         dev_q <= dev_ready;
         ctl_q <= ctl_ready;
      end
   end

   logic [IRQ_N-1:0] cause;
   always_comb begin
      cause            = '0;
      cause[IB_WPF]    = wp_fault;
      cause[IB_ECC]    = ecc_done;
      cause[IB_DERR]   = ecc_done & dec_err;
      cause[IB_DFAIL]  = ecc_done & dec_fail;
      cause[IB_CTL]    = ctl_ready & ~ctl_q;
      cause[IB_DEV]    = dev_ready & ~dev_q;
   end

   logic [IRQ_N-1:0] raw_q;
   frb_irq_latch #(.N(IRQ_N)) u_causes (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (cause),
      .clr     (bus_rd & sel_raw),
      .latched (raw_q)
   );

   logic [RES_W-1:0] result;
   frb_live_status #(.CNT_W(CNT_W)) u_live (
      .clk      (clk),
      .rst_n    (rst_n),
      .ecc_done (ecc_done),
      .dec_fail (dec_fail),
      .dec_err  (dec_err),
      .err_cnt  (err_cnt),
      .ctl_fall (ctl_q & ~ctl_ready),
      .result   (result)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      unique case (1'b1)
         sel_cfg:  bus_rdata[CFG_W-1:0]  = cfg_q;
         sel_tim:  bus_rdata[TIM_W-1:0]  = tim_q;
         sel_mask: bus_rdata[IRQ_N-1:0]  = mask_q;
         sel_raw:  bus_rdata[IRQ_N-1:0]  = raw_q;
         sel_live: bus_rdata[LIVE_W-1:0] = {result, ctl_ready, dev_ready};
         sel_lock: bus_rdata[0]          = unlocked;
         sel_ce:   bus_rdata[0]          = ce_q;
         default:  bus_rdata             = '0;
      endcase
   end

   assign cfg_bits   = cfg_q;
   assign tm_ce_dly  = tim_q.ce_dly;
   assign tm_busy    = tim_q.busy;
   assign tm_turn    = tim_q.turn;
   assign tm_rd_hi   = tim_q.rd_hi;
   assign tm_rd_lo   = tim_q.rd_lo;
   assign tm_wr_hi   = tim_q.wr_hi;
   assign tm_wr_lo   = tim_q.wr_lo;
   assign ce_by_ctrl = ce_q;
   assign irq        = |(raw_q & mask_q);

   assert_masked_cause_raises_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(cause & mask_q)) && !(bus_wr && sel_mask)) |=> irq);

   assert_locked_cfg_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && !(bus_wr && sel_lock)) |=> ($stable(cfg_bits) && $stable(tm_busy)));

endmodule

// File: tb/flash_regbank_tb.sv
module flash_regbank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        dev_ready = 1'b0, ctl_ready = 1'b0, ecc_done = 1'b0;
   logic        dec_err = 1'b0, dec_fail = 1'b0, wp_fault = 1'b0;
   logic [1:0]  err_cnt = '0;
   logic [3:0]  cfg_bits;
   logic [1:0]  tm_ce_dly;
   logic [4:0]  tm_busy;
   logic [2:0]  tm_turn;
   logic [3:0]  tm_rd_hi, tm_rd_lo, tm_wr_hi, tm_wr_lo;
   logic        ce_by_ctrl, irq;

   int compared = 0;
   int mismatched = 0;

   always #2.5 clk = ~clk;

   flash_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dev_ready(dev_ready), .ctl_ready(ctl_ready), .ecc_done(ecc_done),
      .dec_err(dec_err), .dec_fail(dec_fail), .err_cnt(err_cnt),
      .wp_fault(wp_fault), .cfg_bits(cfg_bits), .tm_ce_dly(tm_ce_dly),
      .tm_busy(tm_busy), .tm_turn(tm_turn), .tm_rd_hi(tm_rd_hi),
      .tm_rd_lo(tm_rd_lo), .tm_wr_hi(tm_wr_hi), .tm_wr_lo(tm_wr_lo),
      .ce_by_ctrl(ce_by_ctrl), .irq(irq)
   );

   // behavioural reference model
   bit        m_open;
   bit [3:0]  m_cfg;
   bit [25:0] m_tim;
   bit [5:0]  m_mask, m_raw;
   bit        m_ce, m_dev, m_ctl;
   bit [4:0]  m_res;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_open = 0; m_cfg = 0; m_tim = 0; m_mask = 0; m_raw = 0;
         m_ce = 0; m_dev = 0; m_ctl = 0; m_res = 0;
      end else begin
         bit [5:0] ev;
         ev = {dev_ready && !m_dev, ctl_ready && !m_ctl, ecc_done && dec_fail,
               ecc_done && dec_err, ecc_done, wp_fault};
         if (bus_rd && bus_addr == 3) m_raw = ev;
         else                         m_raw = m_raw | ev;
         if (bus_wr) begin
            if (bus_addr == 5) m_open = (bus_wdata[15:0] == 16'hA25E);
            else if ((bus_addr == 0 || bus_addr == 1) && m_open) begin
               if (bus_addr == 0) m_cfg = bus_wdata[3:0];
               else               m_tim = bus_wdata[25:0];
               m_open = 0;
            end
            if (bus_addr == 2) m_mask = bus_wdata[5:0];
            if (bus_addr == 6) m_ce = bus_wdata[0];
         end
         if (ecc_done) m_res = {dec_fail, err_cnt, dec_err, 1'b1};
         else if (m_ctl && !ctl_ready) m_res = 0;
         m_dev = dev_ready;
         m_ctl = ctl_ready;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison of all outputs against the model
   always begin
      @(posedge clk);
      #1;
      check("R3 cfg_bits", 32'(cfg_bits), 32'(m_cfg));
      check("R5 timing", 32'({tm_ce_dly, tm_busy, tm_turn, tm_rd_hi, tm_rd_lo, tm_wr_hi, tm_wr_lo}), 32'(m_tim));
      check("R6 ce_by_ctrl", 32'(ce_by_ctrl), 32'(m_ce));
      check("R10 irq", 32'(irq), 32'(|(m_raw & m_mask)));
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1.5;
      check(tag, bus_rdata, exp);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ecc_pulse(input logic err, input logic fail, input logic [1:0] cnt);
      @(negedge clk);
      ecc_done = 1'b1; dec_err = err; dec_fail = fail; err_cnt = cnt;
      @(negedge clk);
      ecc_done = 1'b0; dec_err = 1'b0; dec_fail = 1'b0; err_cnt = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_expect(0, 0, "R1 cfg after reset");
      rd_expect(5, 0, "R1 lock after reset");
      rd_expect(3, 0, "R1 causes after reset");
      check("R1 irq after reset", 32'(irq), 0);
      // R4 locked write ignored
      wr(0, 32'hF);
      rd_expect(0, 0, "R4 cfg locked write");
      rd_expect(5, 0, "R4 lock unchanged");
      // R2 / R3 key then one write
      wr(5, 32'h0000_A25E);
      rd_expect(5, 1, "R2 key opens");
      wr(0, 32'h6);
      rd_expect(0, 6, "R3 cfg written");
      rd_expect(5, 0, "R3 relocked");
      wr(0, 32'h9);
      rd_expect(0, 6, "R3 second write ignored");
      // R2 wrong key relocks, upper bits ignored
      wr(5, 32'h0000_A25E);
      wr(5, 32'h0000_1234);
      rd_expect(5, 0, "R2 wrong key");
      wr(5, 32'hFFFF_A25E);
      rd_expect(5, 1, "R2 key upper bits");
      // R5 timing fields
      wr(1, 32'hFEAB_CDEF);
      rd_expect(1, 32'h02AB_CDEF, "R5 timing read");
      check("R5 busy field", 32'(tm_busy), 21);
      check("R5 turn field", 32'(tm_turn), 3);
      check("R5 ce field", 32'(tm_ce_dly), 2);
      check("R5 rd_lo field", 32'(tm_rd_lo), 32'hD);
      wr(1, 0);
      rd_expect(1, 32'h02AB_CDEF, "R4 timing locked write");
      // R6 mask and ce mode
      wr(2, 32'hFFFF_FFFF);
      rd_expect(2, 32'h3F, "R6 mask");
      wr(6, 1);
      check("R6 ce_by_ctrl", 32'(ce_by_ctrl), 1);
      rd_expect(6, 1, "R6 ce read");
      // R10 / R8 fault cause
      @(negedge clk); wp_fault = 1'b1;
      @(negedge clk); wp_fault = 1'b0;
      #1;
      check("R10 irq raised", 32'(irq), 1);
      rd_expect(3, 1, "R8 read returns cause");
      rd_expect(3, 0, "R8 cleared by read");
      check("R10 irq dropped", 32'(irq), 0);
      // R7 / R11 decode with mask off
      wr(2, 0);
      ecc_pulse(1'b1, 1'b0, 2'd2);
      #1;
      check("R10 irq masked off", 32'(irq), 0);
      rd_expect(4, 32'h2C, "R11 live decode");
      rd_expect(3, 6, "R7 decode causes");
      @(negedge clk); dev_ready = 1'b1;
      @(negedge clk); ctl_ready = 1'b1;
      rd_expect(4, 32'h2F, "R11 live levels");
      rd_expect(3, 32'h30, "R7 ready edges");
      @(negedge clk); ctl_ready = 1'b0;
      rd_expect(4, 32'h01, "R11 cleared on ctl fall");
      // R9 cause coincident with clearing read
      ecc_pulse(1'b0, 1'b1, 2'd0);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 3; wp_fault = 1'b1;
      #1.5;
      check("R9 read data excludes new cause", bus_rdata, 32'h0A);
      @(negedge clk);
      bus_rd = 1'b0; wp_fault = 1'b0;
      rd_expect(3, 1, "R9 cause survived");
      // R12 unmapped
      rd_expect(7, 0, "R12 addr 7");
      rd_expect(15, 0, "R12 addr 15");
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule